// File: doc/BRIEF.md
# Speculative Cache Line Violation Tracker

This block watches the private first-level caches of a small group of cores, each running one thread of an ordered sequence of epochs. Per cache line and per core it keeps a valid bit, a tag, a "read while speculative" mark and a "written while speculative" mark. When any core stores to a line, an invalidate carrying that core's place in the epoch order reaches the other cores one cycle later. Only the cores younger than the writer act on it. A younger core that had speculatively read the same line raises a sticky violation flag.

The flag has no immediate effect. When the oldest core asks to commit, the block answers one cycle later with either an acknowledgement or a recovery request, depending on the flag. An acknowledgement clears that core's marks and passes oldest status to the next core in round-robin order. A recovery request clears the marks and the flag, and the same core stays oldest so that it can run its epoch again. Losing speculative state also counts as a violation. This covers an explicit eviction and a replacement of a marked line by a different tag. Tracking is done per line: any two addresses that share an index and a tag conflict with each other.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every violation flag, acknowledgement and recovery output is 0, and core 0 is oldest (`oldest_o` = 1 in bit 0).
- R2: Each core issues at most one request per cycle. The operation codes are 0 load, 1 store, 2 evict and 3 commit. The line index is the address bits [IDX_W-1:0] and the tag is the remaining upper bits. A load by a core that is not oldest sets the read mark, and a store by such a core sets the write mark. Accesses by the oldest core set neither mark.
- R3: Core S stores in cycle T. During T+1, every core that is younger than S at time T and holds a read mark on a valid line with the same index and tag sets its violation flag. The flag is visible from T+2. The line is then dropped.
- R4: An invalidate causes no violation in these cases: it comes from a younger core, its tag differs from the stored tag, or the matching line carries only a write mark.
- R5: A load that hits a line the same core already wrote in its current epoch does not set the read mark.
- R6: Evicting a valid line that carries either mark sets the flag in the next cycle. Evicting an unmarked line, or a line that is not present, does not set it.
- R7: A load or store that replaces a valid, marked line with a different tag sets the flag in the next cycle.
- R8: Order runs round-robin starting at the oldest core. A commit by the oldest core produces a one-cycle pulse on the next cycle: `commit_ack_o` if its flag was clear, otherwise `commit_recover_o`. The commit clears that core's marks and flag. After an acknowledgement, oldest moves to the next core index, wrapping to 0. After a recovery request, oldest stays where it is.
- R9: A commit from a core that is not oldest is ignored. No response is produced, and the flag and marks are kept.
- R10: A violation flag stays set through later loads, stores and idle cycles until that core's own commit completes, and that commit is always answered with a recovery request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORES | Per-core request valid |
| req_op | input | 2*NCORES | Per-core operation code, 2 bits per core |
| req_addr | input | NCORES*ADDR_W | Per-core line address |
| oldest_o | output | NCORES | One-hot marker of the oldest (non-speculative) core |
| viol_flag_o | output | NCORES | Sticky per-core violation flag |
| commit_ack_o | output | NCORES | One-cycle commit acknowledgement |
| commit_recover_o | output | NCORES | One-cycle recovery request in place of an acknowledgement |

## Verification
The bench goes after the invalidate timing and the ordering filter. A design that checked invalidates in the store cycle would raise the flag one cycle early. A design that ignored epoch order would flag an older core when a younger core writes. It also targets the cases where marks must be absent, and a design that got these wrong would raise false violations. These cases are a load after the core's own store, accesses by the oldest core, and invalidates with a mismatched tag. Commit handling is checked at the non-oldest core, at a flagged core, and at the wrap of the oldest pointer. Errors there show up as spurious answers, an acknowledgement where a recovery request is due, or oldest status advancing after a recovery request.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_EVICT  = 2'd2,
    OP_COMMIT = 2'd3
  } trk_op_e;

  // Position of a core in epoch order, 0 = oldest.
  function automatic int unsigned epoch_rank(int unsigned core, int unsigned head,
                                             int unsigned ncores);
    return (core + ncores - head) % ncores;
  endfunction

  // True when core a runs a later epoch than core b.
  function automatic logic is_younger(int unsigned a, int unsigned b, int unsigned head,
                                      int unsigned ncores);
    return epoch_rank(a, head, ncores) > epoch_rank(b, head, ncores);
  endfunction

endpackage

// File: rtl/spec_trk_order.sv
module spec_trk_order #(
  parameter int NCORES = 4,
  localparam int CORE_W = $clog2(NCORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCORES-1:0] ack_fire,
  output logic [CORE_W-1:0] head_o,
  output logic [NCORES-1:0] oldest_o
);

  logic [CORE_W-1:0] head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
    end else if (|ack_fire) begin
      head_q <= (head_q == CORE_W'(NCORES - 1)) ? '0 : head_q + 1'b1;
    end
  end

  assign head_o   = head_q;
  assign oldest_o = {{(NCORES-1){1'b0}}, 1'b1} << head_q;

endmodule

// File: rtl/spec_trk_bcast.sv
module spec_trk_bcast import spec_trk_pkg::*; #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 10,
  localparam int CORE_W = $clog2(NCORES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCORES-1:0]          st_fire,
  input  logic [NCORES*ADDR_W-1:0]   st_addr,
  input  logic [CORE_W-1:0]          head,
  output logic [NCORES-1:0]          inv_v_o,
  output logic [NCORES*ADDR_W-1:0]   inv_addr_o,
  output logic [NCORES*NCORES-1:0]   inv_ymask_o
);

  // Bit s*NCORES+j: receiver j is younger than sender s at store time.
  logic [NCORES*NCORES-1:0] ymask_d;

  always_comb begin
    for (int s = 0; s < NCORES; s++) begin
      for (int j = 0; j < NCORES; j++) begin
        ymask_d[s*NCORES+j] = st_fire[s] && is_younger(j, s, 32'(head), NCORES);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_v_o     <= '0;
      inv_addr_o  <= '0;
      inv_ymask_o <= '0;
    end else begin
      inv_v_o     <= st_fire;
      inv_addr_o  <= st_addr;
      inv_ymask_o <= ymask_d;
    end
  end

endmodule

// File: rtl/spec_trk_core.sv
module spec_trk_core import spec_trk_pkg::*; #(
  parameter int NCORES = 4,
  parameter int NLINES = 16,
  parameter int ADDR_W = 10,
  localparam int IDX_W = $clog2(NLINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_v,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     is_oldest,
  input  logic [NCORES-1:0]        inv_v,
  input  logic [NCORES*ADDR_W-1:0] inv_addr,
  input  logic [NCORES-1:0]        inv_for_me,
  output logic                     viol_o,
  output logic                     ack_o,
  output logic                     rec_o,
  output logic                     commit_fire_o,
  output logic                     inv_hit_o,
  output logic                     evict_hit_o,
  output logic                     repl_hit_o
);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [NLINES-1:0] vld_q, vld_n, rd_q, rd_n, md_q, md_n;
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [TAG_W-1:0]  tag_n [NLINES];
  logic              viol_q, viol_n, ack_q, rec_q;
  logic              inv_hit, ev_hit, rp_hit, cfire, report;
  logic [IDX_W-1:0]  iix, lix;
  logic [TAG_W-1:0]  itg, ltg;
  logic              lhit, lmark;

  always_comb begin
    vld_n  = vld_q;
    rd_n   = rd_q;
    md_n   = md_q;
    tag_n  = tag_q;
    inv_hit = 1'b0;
    ev_hit  = 1'b0;
    rp_hit  = 1'b0;
    cfire   = 1'b0;
    report  = 1'b0;
    iix     = '0;
    itg     = '0;

    // Invalidates from older writers land first.
    for (int s = 0; s < NCORES; s++) begin
      if (inv_v[s] && inv_for_me[s]) begin
        iix = idx_of(inv_addr[s*ADDR_W +: ADDR_W]);
        itg = tag_of(inv_addr[s*ADDR_W +: ADDR_W]);
        if (vld_n[iix] && tag_n[iix] == itg) begin
          if (rd_n[iix]) begin
            inv_hit   = 1'b1;
            vld_n[iix] = 1'b0;
            rd_n[iix]  = 1'b0;
            md_n[iix]  = 1'b0;
          end else if (!md_n[iix]) begin
            vld_n[iix] = 1'b0;
          end
        end
      end
    end

    // Then the core's own request.
    lix   = idx_of(req_addr);
    ltg   = tag_of(req_addr);
    lhit  = vld_n[lix] && tag_n[lix] == ltg;
    lmark = rd_n[lix] | md_n[lix];

    if (req_v) begin
      case (trk_op_e'(req_op))
        OP_LOAD: begin
          if (lhit) begin
            if (!is_oldest && !md_n[lix]) rd_n[lix] = 1'b1;
          end else begin
            rp_hit     = vld_n[lix] && lmark;
            vld_n[lix] = 1'b1;
            tag_n[lix] = ltg;
            rd_n[lix]  = !is_oldest;
            md_n[lix]  = 1'b0;
          end
        end
        OP_STORE: begin
          if (lhit) begin
            if (!is_oldest) md_n[lix] = 1'b1;
          end else begin
            rp_hit     = vld_n[lix] && lmark;
            vld_n[lix] = 1'b1;
            tag_n[lix] = ltg;
            rd_n[lix]  = 1'b0;
            md_n[lix]  = !is_oldest;
          end
        end
        OP_EVICT: begin
          if (lhit) begin
            ev_hit     = lmark;
            vld_n[lix] = 1'b0;
            rd_n[lix]  = 1'b0;
            md_n[lix]  = 1'b0;
          end
        end
        OP_COMMIT: begin
          if (is_oldest) begin
            cfire  = 1'b1;
            report = viol_q | inv_hit;
            rd_n   = '0;
            md_n   = '0;
          end
        end
        default: ;
      endcase
    end

    viol_n = cfire ? 1'b0 : (viol_q | inv_hit | ev_hit | rp_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_q   <= '0;
      md_q   <= '0;
      viol_q <= 1'b0;
      ack_q  <= 1'b0;
      rec_q  <= 1'b0;
      for (int l = 0; l < NLINES; l++) tag_q[l] <= '0;
    end else begin
      vld_q  <= vld_n;
      rd_q   <= rd_n;
      md_q   <= md_n;
      tag_q  <= tag_n;
      viol_q <= viol_n;
      ack_q  <= cfire && !report;
      rec_q  <= cfire && report;
    end
  end

  assign viol_o        = viol_q;
  assign ack_o         = ack_q;
  assign rec_o         = rec_q;
  assign commit_fire_o = cfire;
  assign inv_hit_o     = inv_hit;
  assign evict_hit_o   = ev_hit;
  assign repl_hit_o    = rp_hit;

endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker import spec_trk_pkg::*; #(
  parameter int NCORES = 4,
  parameter int NLINES = 16,
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCORES-1:0]        req_valid,
  input  logic [2*NCORES-1:0]      req_op,
  input  logic [NCORES*ADDR_W-1:0] req_addr,
  output logic [NCORES-1:0]        oldest_o,
  output logic [NCORES-1:0]        viol_flag_o,
  output logic [NCORES-1:0]        commit_ack_o,
  output logic [NCORES-1:0]        commit_recover_o
);

  localparam int CORE_W = $clog2(NCORES);

  logic [CORE_W-1:0]          head_w;
  logic [NCORES-1:0]          st_fire_w;
  logic [NCORES-1:0]          inv_v_w;
  logic [NCORES*ADDR_W-1:0]   inv_addr_w;
  logic [NCORES*NCORES-1:0]   inv_ymask_w;
  // Internal events brought out for the checker.
  logic [NCORES-1:0]          commit_fire_w;
  logic [NCORES-1:0]          inv_hit_w;
  logic [NCORES-1:0]          evict_hit_w;
  logic [NCORES-1:0]          repl_hit_w;

  always_comb begin
    for (int c = 0; c < NCORES; c++) begin
      st_fire_w[c] = req_valid[c] && (trk_op_e'(req_op[2*c +: 2]) == OP_STORE);
    end
  end

  spec_trk_order #(.NCORES(NCORES)) u_order (
    .clk      (clk),
    .rst      (rst),
    .ack_fire (commit_fire_w & ~commit_recover_next()),
    .head_o   (head_w),
    .oldest_o (oldest_o)
  );

  spec_trk_bcast #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_bcast (
    .clk         (clk),
    .rst         (rst),
    .st_fire     (st_fire_w),
    .st_addr     (req_addr),
    .head        (head_w),
    .inv_v_o     (inv_v_w),
    .inv_addr_o  (inv_addr_w),
    .inv_ymask_o (inv_ymask_w)
  );

  // A commit is answered with recovery when the flag is set or a hit lands now.
  function automatic logic [NCORES-1:0] commit_recover_next();
    return viol_flag_o | inv_hit_w;
  endfunction

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [NCORES-1:0] for_me;

    always_comb begin
      for (int s = 0; s < NCORES; s++) for_me[s] = inv_ymask_w[s*NCORES + c];
    end

    spec_trk_core #(.NCORES(NCORES), .NLINES(NLINES), .ADDR_W(ADDR_W)) u_core (
      .clk           (clk),
      .rst           (rst),
      .req_v         (req_valid[c]),
      .req_op        (req_op[2*c +: 2]),
      .req_addr      (req_addr[c*ADDR_W +: ADDR_W]),
      .is_oldest     (oldest_o[c]),
      .inv_v         (inv_v_w),
      .inv_addr      (inv_addr_w),
      .inv_for_me    (for_me),
      .viol_o        (viol_flag_o[c]),
      .ack_o         (commit_ack_o[c]),
      .rec_o         (commit_recover_o[c]),
      .commit_fire_o (commit_fire_w[c]),
      .inv_hit_o     (inv_hit_w[c]),
      .evict_hit_o   (evict_hit_w[c]),
      .repl_hit_o    (repl_hit_w[c])
    );
  end

endmodule

// File: rtl/spec_line_tracker_chk.sv
module spec_line_tracker_chk #(
  parameter int NCORES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NCORES-1:0] oldest_o,
  input logic [NCORES-1:0] viol_flag_o,
  input logic [NCORES-1:0] commit_ack_o,
  input logic [NCORES-1:0] commit_recover_o,
  input logic [NCORES-1:0] commit_fire_w,
  input logic [NCORES-1:0] inv_hit_w,
  input logic [NCORES-1:0] evict_hit_w,
  input logic [NCORES-1:0] repl_hit_w
);

  logic [NCORES-1:0] set_ev;
  assign set_ev = (inv_hit_w | evict_hit_w | repl_hit_w) & ~commit_fire_w;

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_o) == 1); // R8

  AST_ANSWER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (commit_ack_o & commit_recover_o) == '0); // R8

  AST_ANSWER_ONLY_OLDEST: assert property (@(posedge clk) disable iff (rst)
    ((commit_ack_o | commit_recover_o) & ~$past(oldest_o)) == '0); // R9

  AST_ACK_ROTATES: assert property (@(posedge clk) disable iff (rst)
    (|commit_ack_o) |-> (oldest_o == {commit_ack_o[NCORES-2:0], commit_ack_o[NCORES-1]})); // R8

  AST_RECOVER_KEEPS_OLDEST: assert property (@(posedge clk) disable iff (rst)
    (|commit_recover_o) |-> (oldest_o == commit_recover_o)); // R8

  AST_ANSWER_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((commit_ack_o | commit_recover_o) & viol_flag_o) == '0); // R8

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (|set_ev) |=> (($past(set_ev) & ~viol_flag_o) == '0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(viol_flag_o & ~commit_fire_w)) |=>
      ((($past(viol_flag_o) & ~$past(commit_fire_w)) & ~viol_flag_o) == '0)); // R10

  AST_RECOVER_NEEDS_VIOL: assert property (@(posedge clk) disable iff (rst)
    (commit_recover_o & ~$past(viol_flag_o | inv_hit_w)) == '0); // R10

endmodule

bind spec_line_tracker spec_line_tracker_chk #(.NCORES(NCORES)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .oldest_o         (oldest_o),
  .viol_flag_o      (viol_flag_o),
  .commit_ack_o     (commit_ack_o),
  .commit_recover_o (commit_recover_o),
  .commit_fire_w    (commit_fire_w),
  .inv_hit_w        (inv_hit_w),
  .evict_hit_w      (evict_hit_w),
  .repl_hit_w       (repl_hit_w)
);

// File: tb/spec_line_tracker_tb_top.sv
module spec_line_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 16;
  localparam int AW = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NC-1:0]    req_valid = '0;
  logic [2*NC-1:0]  req_op = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC-1:0]    oldest_o, viol_flag_o, commit_ack_o, commit_recover_o;

  spec_line_tracker #(.NCORES(NC), .NLINES(NL), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .oldest_o(oldest_o), .viol_flag_o(viol_flag_o), .commit_ack_o(commit_ack_o),
    .commit_recover_o(commit_recover_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Behavioural reference: plain integer tables per core and line.
  int m_vld[NC][NL], m_tag[NC][NL], m_rd[NC][NL], m_md[NC][NL];
  int m_viol[NC], m_ack[NC], m_rec[NC];
  int m_head = 0;
  int pq_addr[$], pq_mask[$];
  int s_v[NC], s_op[NC], s_addr[NC];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int mk(int tg, int ix);
    return tg * NL + ix;
  endfunction

  function automatic int to_mask(int v[NC]);
    int m = 0;
    for (int c = 0; c < NC; c++) if (v[c] != 0) m |= (1 << c);
    return m;
  endfunction

  function automatic int order_pos(int c, int hd);
    return (c - hd + NC) % NC;
  endfunction

  task automatic put(int c, int op, int a);
    s_v[c] = 1; s_op[c] = op; s_addr[c] = a;
  endtask

  task automatic model_step();
    int pa[$], pm[$];
    int hd = m_head;
    bit any_ack = 0;
    pa = pq_addr; pm = pq_mask;
    pq_addr.delete(); pq_mask.delete();
    for (int c = 0; c < NC; c++) begin
      bit hit = 0, lost = 0, done_commit = 0, old = (c == hd);
      m_ack[c] = 0; m_rec[c] = 0;
      foreach (pa[k]) begin
        if ((pm[k] >> c) & 1) begin
          int ix = pa[k] % NL, tg = pa[k] / NL;
          if (m_vld[c][ix] != 0 && m_tag[c][ix] == tg) begin
            if (m_rd[c][ix] != 0) begin
              hit = 1; m_vld[c][ix] = 0; m_rd[c][ix] = 0; m_md[c][ix] = 0;
            end else if (m_md[c][ix] == 0) m_vld[c][ix] = 0;
          end
        end
      end
      if (s_v[c] != 0) begin
        int ix = s_addr[c] % NL, tg = s_addr[c] / NL;
        bit present = (m_vld[c][ix] != 0) && (m_tag[c][ix] == tg);
        bit marked = (m_rd[c][ix] != 0) || (m_md[c][ix] != 0);
        case (s_op[c])
          0: if (present) begin
               if (!old && m_md[c][ix] == 0) m_rd[c][ix] = 1;
             end else begin
               if (m_vld[c][ix] != 0 && marked) lost = 1;
               m_vld[c][ix] = 1; m_tag[c][ix] = tg; m_rd[c][ix] = !old; m_md[c][ix] = 0;
             end
          1: if (present) begin
               if (!old) m_md[c][ix] = 1;
             end else begin
               if (m_vld[c][ix] != 0 && marked) lost = 1;
               m_vld[c][ix] = 1; m_tag[c][ix] = tg; m_rd[c][ix] = 0; m_md[c][ix] = !old;
             end
          2: if (present) begin
               if (marked) lost = 1;
               m_vld[c][ix] = 0; m_rd[c][ix] = 0; m_md[c][ix] = 0;
             end
          default: if (old) begin
               done_commit = 1;
               if (m_viol[c] != 0 || hit) m_rec[c] = 1;
               else begin m_ack[c] = 1; any_ack = 1; end
               for (int l = 0; l < NL; l++) begin m_rd[c][l] = 0; m_md[c][l] = 0; end
               m_viol[c] = 0;
             end
        endcase
      end
      if (!done_commit && (hit || lost)) m_viol[c] = 1;
    end
    for (int s = 0; s < NC; s++) begin
      if (s_v[s] != 0 && s_op[s] == 1) begin
        int m = 0;
        for (int j = 0; j < NC; j++) if (order_pos(j, hd) > order_pos(s, hd)) m |= (1 << j);
        pq_addr.push_back(s_addr[s]); pq_mask.push_back(m);
      end
    end
    if (any_ack) m_head = (hd + 1) % NC;
  endtask

  task automatic compare_all();
    chk("R3 R10 violation flags vs model", int'(viol_flag_o), to_mask(m_viol));
    chk("R8 acknowledge vs model", int'(commit_ack_o), to_mask(m_ack));
    chk("R8 R10 recover vs model", int'(commit_recover_o), to_mask(m_rec));
    chk("R8 oldest vs model", int'(oldest_o), 1 << m_head);
  endtask

  // Drive staged requests, advance the model, sample at the next falling edge.
  task automatic tick();
    for (int c = 0; c < NC; c++) begin
      req_valid[c] = (s_v[c] != 0);
      req_op[2*c +: 2] = 2'(s_op[c]);
      req_addr[c*AW +: AW] = AW'(s_addr[c]);
    end
    model_step();
    for (int c = 0; c < NC; c++) s_v[c] = 0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    int a;
    for (int c = 0; c < NC; c++) begin
      s_v[c] = 0; s_op[c] = 0; s_addr[c] = 0;
      m_viol[c] = 0; m_ack[c] = 0; m_rec[c] = 0;
      for (int l = 0; l < NL; l++) begin
        m_vld[c][l] = 0; m_tag[c][l] = 0; m_rd[c][l] = 0; m_md[c][l] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oldest after reset", int'(oldest_o), 1);
    chk("R1 flags after reset", int'(viol_flag_o), 0);
    chk("R1 answers after reset", int'(commit_ack_o | commit_recover_o), 0);

    // R2: the oldest core's own accesses leave no marks.
    put(0, 0, mk(1, 3)); put(0, 1, mk(2, 4)); tick();
    put(0, 2, mk(1, 3)); tick();
    put(0, 2, mk(2, 4)); tick();
    chk("R2 oldest evicts unmarked lines", int'(viol_flag_o[0]), 0);

    // R3: older store against a younger speculative read.
    a = mk(2, 5);
    put(1, 0, a); tick();
    put(0, 1, a); tick();
    chk("R3 flag not yet set one cycle after store", int'(viol_flag_o[1]), 0);
    tick();
    chk("R3 flag set two cycles after store", int'(viol_flag_o[1]), 1);

    // R4: younger writer, different tag, write-only mark.
    put(2, 0, mk(1, 7)); tick();
    put(3, 1, mk(1, 7)); tick(); tick();
    chk("R4 younger writer ignored", int'(viol_flag_o[2]), 0);
    put(0, 1, mk(3, 7)); tick(); tick();
    chk("R4 tag mismatch ignored", int'(viol_flag_o[2]), 0);
    put(3, 1, mk(1, 9)); tick();
    put(0, 1, mk(1, 9)); tick(); tick();
    chk("R4 write-only mark ignored", int'(viol_flag_o[3]), 0);

    // R5: read after own write is not exposed.
    put(2, 1, mk(1, 10)); tick();
    put(2, 0, mk(1, 10)); tick();
    put(0, 1, mk(1, 10)); tick(); tick();
    chk("R5 load after own store unmarked", int'(viol_flag_o[2]), 0);

    // R6: evictions.
    put(2, 2, mk(1, 12)); tick();
    chk("R6 evict of absent line", int'(viol_flag_o[2]), 0);
    put(3, 2, mk(1, 9)); tick();
    chk("R6 evict of marked line", int'(viol_flag_o[3]), 1);

    // R7: replacement of a marked line.
    put(2, 0, mk(1, 11)); tick();
    put(2, 0, mk(2, 11)); tick();
    chk("R7 replacement of marked line", int'(viol_flag_o[2]), 1);

    // R9: commit from a core that is not oldest.
    put(1, 3, 0); tick();
    chk("R9 no answer to younger commit", int'(commit_ack_o | commit_recover_o), 0);
    chk("R9 flag kept after ignored commit", int'(viol_flag_o[1]), 1);

    // R8: clean commit by the oldest core.
    put(0, 3, 0); tick();
    chk("R8 acknowledge pulse", int'(commit_ack_o), 1);
    chk("R8 no recover on clean commit", int'(commit_recover_o), 0);
    chk("R8 oldest advances", int'(oldest_o), 2);
    tick();
    chk("R8 acknowledge lasts one cycle", int'(commit_ack_o), 0);

    // R8 R10: flagged commit answered with recovery.
    put(1, 3, 0); tick();
    chk("R10 flagged commit recovers", int'(commit_recover_o), 2);
    chk("R8 oldest kept after recovery", int'(oldest_o), 2);
    chk("R8 flag cleared by commit", int'(viol_flag_o[1]), 0);
    put(1, 3, 0); tick();
    chk("R8 rerun commit acknowledged", int'(commit_ack_o), 2);

    // R10: stickiness, then drain to wrap.
    put(2, 0, mk(0, 1)); tick(); tick(); tick();
    chk("R10 flag stays set", int'(viol_flag_o[2]), 1);
    put(2, 3, 0); tick();
    chk("R10 sticky flag reported", int'(commit_recover_o), 4);
    put(2, 3, 0); tick();
    put(3, 3, 0); tick();
    chk("R10 evict violation reported", int'(commit_recover_o), 8);
    put(3, 3, 0); tick();
    chk("R8 oldest wraps to core 0", int'(oldest_o), 1);

    // Random traffic against the model.
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(0, 9) < 6) begin
          int r = $urandom_range(0, 19);
          put(c, (r < 8) ? 0 : (r < 14) ? 1 : (r < 17) ? 2 : 3, $urandom_range(0, 3 * NL - 1));
        end
      end
      tick();
    end

    finish_run();
  end

endmodule